// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave end of a two-wire serial byte memory. It oversamples the serial clock and data lines with the system clock, finds start and stop conditions, and frames the bytes that follow. The first byte after a start must carry the fixed device type 1010000 plus a direction bit. A write command then takes a two-byte memory address, high byte first, and any number of data bytes. The data bytes collect in a page buffer. The stop that ends the write hands them to a self-timed programming cycle, which copies them into the internal array. A read command streams bytes out of the array from the current address for as long as the master acknowledges them.

The data line is open drain: the block only reports when it pulls the line low (`sda_oe`). A write-control input blocks data bytes without blocking addressing. While programming runs, `busy` is high and the block ignores the bus completely.

Control is one state machine. In `ST_IDLE` the block waits for a start. A start moves any state except `ST_PROG` to `ST_DEV`. In `ST_DEV` the block receives the select byte. On a match it goes to `ST_ACK`; on a mismatch it goes back to `ST_IDLE`. `ST_ACK` holds the ninth clock (acknowledge driven or withheld) and leaves on its falling edge for the state stored for after the slot:
- `ST_ADDR_HI` after a write select.
- `ST_ADDR_LO` after the high address byte.
- `ST_WDATA` after the low address byte and after each data byte.
- `ST_RDATA` after a read select.

`ST_RDATA` shifts out eight bits and then enters `ST_RACK`. From `ST_RACK` the block goes back to `ST_RDATA` on a master ACK, or to `ST_IDLE` on a NoACK. A stop outside `ST_PROG` goes to `ST_PROG` when a write command has buffered data, and to `ST_IDLE` otherwise. `ST_PROG` returns to `ST_IDLE` when the timer expires.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: While and after reset, `sda_oe` and `busy` are low, and every array byte reads as 8'hFF until it is written.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bytes clocked in without a preceding start are not acknowledged.
- R3: The first byte after a start is received MSB first. Its bits [7:1] must equal 7'b1010000 and bit [0] gives the direction (1 read, 0 write). A mismatching byte is not acknowledged, and all later bytes are ignored until the next start.
- R4: Every accepted received byte is acknowledged by pulling SDA low for the ninth clock. `sda_oe` changes only while SCL is low.
- R5: The memory address is two bytes, high byte first. Only the low ADDR_W bits of the 16 are used, and the higher bits are ignored.
- R6: Write data is buffered and reaches the array only after the stop. The address advances only in its low PAGE_W bits, wrapping inside the current page, so later bytes overwrite earlier ones when more than 2^PAGE_W arrive.
- R7: With `wc_i` high, the select and address bytes are still acknowledged, data bytes are not, and the array is left unchanged.
- R8: A stop that ends a write command holding at least one accepted data byte raises `busy` for exactly PROG_CYCLES clocks (PROG_CYCLES >= 2^PAGE_W). A stop with no accepted data byte leaves `busy` low.
- R9: While `busy` is high, no start, select byte or stop is answered, and `sda_oe` stays low.
- R10: A read that starts with no new address returns the byte after the last byte read or written.
- R11: A write select plus two address bytes, followed by a repeated start with a read select, reads from that address.
- R12: While the master acknowledges, reads continue at incrementing addresses and wrap from the top of the array to 0. After a NoACK the block releases SDA and returns to standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| wc_i | input | 1 | Write control; high refuses data bytes (tie low when unused) |
| sda_oe | output | 1 | High pulls the data line low (open-drain enable) |
| busy | output | 1 | High while the programming cycle runs |

## Verification
The hardest case to reach from the ports is the interaction with a running programming cycle. A start and select byte must arrive while `busy` is high, so the bench sends them at once after the stop of a write. It uses a programming time long enough to cover a whole byte and its acknowledge slot. Page wrap and overwrite are reached by sending more bytes than a page holds, starting at an offset inside the page. A sequential read across the whole page and its neighbours then shows which bytes won. A small array lets the bench fill every page and read the whole array back, including the wrap from the top address to 0.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_PROG
    } ee_state_e;

    localparam logic [6:0] DEV_TYPE = 7'b1010000;
endpackage

// File: rtl/eeprom_bus_cond.sv
module eeprom_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_q, sda_q;
    logic       scl_s;

    // two-flop synchronizers plus one delay stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_q    <= scl_sync[1];
            sda_q    <= sda_sync[1];
        end
    end

    assign scl_s     = scl_sync[1];
    assign sda_s     = sda_sync[1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [PAGE_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] raddr,
    output logic [7:0]        rdata,
    output logic              rvalid,
    output logic              any_valid
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   vld_q <= '0;
        else if (clr) vld_q <= '0;
        else if (we)  vld_q[waddr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) buf_q[waddr] <= wdata;
    end

    assign rdata     = buf_q[raddr];
    assign rvalid    = vld_q[raddr];
    assign any_valid = |vld_q;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    // stand-in storage: erased (all ones) after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
    parameter int PROG_CYCLES = 100,
    localparam int TW = $clog2(PROG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [TW-1:0] cnt,
    output logic          done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign done = run && (cnt == TW'(PROG_CYCLES - 1));
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 6,
    parameter int PROG_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wc_i,
    output logic sda_oe,
    output logic busy
);
    import eeprom_pkg::*;

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int TW         = $clog2(PROG_CYCLES + 1);

    ee_state_e         st_q, st_d, ret_q;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [2:0]        cnt_q;
    logic              got8_q, ack_q, mack_q, wr_q;
    logic [7:0]        rx_q, tx_q, ahi_q;
    logic [ADDR_W-1:0] addr_q;
    logic              byte_end, dev_match;
    logic [7:0]        mem_rd, pb_rd;
    logic              pb_we, pb_clr, pb_rvalid, pb_any;
    logic [TW-1:0]     tcnt;
    logic              tmr_run, tmr_done, commit_we;
    logic [PAGE_W-1:0] cidx;

    eeprom_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_end  = scl_fall && got8_q;
    assign dev_match = (rx_q[7:1] == DEV_TYPE);
    assign tmr_run   = (st_q == ST_PROG);
    assign cidx      = tcnt[PAGE_W-1:0];
    assign commit_we = tmr_run && (tcnt < TW'(PAGE_BYTES)) && pb_rvalid;
    assign pb_we     = (st_q == ST_WDATA) && byte_end && !wc_i;
    assign pb_clr    = ((st_q == ST_DEV) && byte_end) || tmr_done;

    eeprom_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .cnt(tcnt), .done(tmr_done)
    );

    eeprom_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we),
        .waddr(addr_q[PAGE_W-1:0]), .wdata(rx_q), .raddr(cidx),
        .rdata(pb_rd), .rvalid(pb_rvalid), .any_valid(pb_any)
    );

    eeprom_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(commit_we),
        .waddr({addr_q[ADDR_W-1:PAGE_W], cidx}), .wdata(pb_rd),
        .raddr(addr_q), .rdata(mem_rd)
    );

    // next state
    always_comb begin
        st_d = st_q;
        if (st_q == ST_PROG) begin
            if (tmr_done) st_d = ST_IDLE;
        end else if (start_det) begin
            st_d = ST_DEV;
        end else if (stop_det) begin
            st_d = (wr_q && pb_any) ? ST_PROG : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_PROG: ;
                ST_DEV:     if (byte_end) st_d = dev_match ? ST_ACK : ST_IDLE;
                ST_ADDR_HI,
                ST_ADDR_LO,
                ST_WDATA:   if (byte_end) st_d = ST_ACK;
                ST_ACK:     if (scl_fall) st_d = ret_q;
                ST_RDATA:   if (scl_fall && cnt_q == 3'd7) st_d = ST_RACK;
                ST_RACK:    if (scl_fall) st_d = mack_q ? ST_RDATA : ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath: bit framing, address and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q  <= ST_IDLE;
            cnt_q  <= '0;
            got8_q <= 1'b0;
            ack_q  <= 1'b0;
            mack_q <= 1'b0;
            wr_q   <= 1'b0;
            rx_q   <= '0;
            tx_q   <= '0;
            ahi_q  <= '0;
            addr_q <= '0;
        end else if (st_q == ST_PROG) begin
            if (tmr_done) wr_q <= 1'b0;
        end else if (start_det) begin
            cnt_q  <= '0;
            got8_q <= 1'b0;
        end else begin
            case (st_q)
                ST_DEV, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_q  <= {rx_q[6:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == 3'd7) got8_q <= 1'b1;
                    end
                    if (byte_end) begin
                        got8_q <= 1'b0;
                        ack_q  <= 1'b1;
                        case (st_q)
                            ST_DEV: if (dev_match) begin
                                wr_q  <= ~rx_q[0];
                                ret_q <= rx_q[0] ? ST_RDATA : ST_ADDR_HI;
                            end
                            ST_ADDR_HI: begin
                                ahi_q <= rx_q;
                                ret_q <= ST_ADDR_LO;
                            end
                            ST_ADDR_LO: begin
                                addr_q <= ADDR_W'({ahi_q, rx_q});
                                ret_q  <= ST_WDATA;
                            end
                            default: begin
                                ack_q <= ~wc_i;
                                ret_q <= ST_WDATA;
                                if (!wc_i)
                                    addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: if (scl_fall && ret_q == ST_RDATA) begin
                    tx_q   <= mem_rd;
                    addr_q <= addr_q + 1'b1;
                    cnt_q  <= '0;
                end
                ST_RDATA: if (scl_fall) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q != 3'd7) tx_q <= {tx_q[6:0], 1'b0};
                end
                ST_RACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall && mack_q) begin
                        tx_q   <= mem_rd;
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = ((st_q == ST_ACK) && ack_q) || ((st_q == ST_RDATA) && !tx_q[7]);
        busy   = (st_q == ST_PROG);
    end
endmodule

// File: rtl/eeprom_i2c_chk.sv
module eeprom_i2c_chk #(
    parameter int PROG_CYCLES = 100
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic busy
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!sda_oe && !busy));

    // R4
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == PROG_CYCLES);

    // R8
    busy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < PROG_CYCLES);

    // R9
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);
endmodule

bind eeprom_i2c_slave eeprom_i2c_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy(busy)
);

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 8;
    localparam int PW    = 6;
    localparam int PROG  = 400;
    localparam int DEPTH = 1 << AW;
    localparam int PGB   = 1 << PW;
    localparam int Q     = 5;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wc = 1'b0;
    logic sda_oe, busy, sda_bus;
    int   nchecks = 0, nerr = 0, busy_cnt = 0, cyc = 0;
    bit   reported = 1'b0;
    logic [7:0] model [DEPTH];
    int   cur = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_i2c_slave #(.ADDR_W(AW), .PAGE_W(PW), .PROG_CYCLES(PROG)) i_eeprom_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .wc_i(wc),
        .sda_oe(sda_oe), .busy(busy)
    );

    always @(negedge clk) if (busy) busy_cnt++;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 195000) begin
            nchecks++; nerr++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(2);
        acked = ~sda_bus;
        tick(Q-2); scl = 1'b0; tick(Q);
    endtask

    task automatic send_chk(input logic [7:0] b, input int exp_ack, input string tag);
        logic a;
        send_byte(b, a);
        chk(tag, int'(a), exp_ack);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q); scl = 1'b1; tick(2);
            d[i] = sda_bus;
            tick(Q-2); scl = 1'b0; tick(Q);
        end
        sda_m = ~give_ack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int k, input int s);
        return 8'((k * 37 + s * 11 + 5) & 255);
    endfunction

    // page write of n bytes at 16-bit address a16, data seeded by s
    task automatic wr_seq(input int a16, input int n, input int s, input string tag);
        int eff, page;
        eff  = a16 % DEPTH;
        page = eff & ~(PGB - 1);
        i2c_start();
        send_chk(8'hA0, 1, "R3 write select ack");
        send_chk(8'(a16 >> 8), 1, "R5 high address ack");
        send_chk(8'(a16), 1, "R4 low address ack");
        for (int k = 0; k < n; k++) begin
            send_chk(pat(k, s), 1, tag);
            model[page | ((eff + k) & (PGB - 1))] = pat(k, s);
        end
        cur = page | ((eff + n) & (PGB - 1));
        busy_cnt = 0;
        i2c_stop();
    endtask

    task automatic wait_prog();
        while (busy) tick(1);
        chk("R8 busy length", busy_cnt, PROG);
    endtask

    task automatic recv_chk(input int n, input string tag);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            chk(tag, int'(d), int'(model[(cur + k) % DEPTH]));
        end
        cur = (cur + n) % DEPTH;
        i2c_stop();
        chk("R12 released after NoACK", int'(sda_oe), 0);
    endtask

    task automatic rd_seq(input int a16, input int n, input string tag);
        i2c_start();
        send_chk(8'hA0, 1, "R11 dummy write select");
        send_chk(8'(a16 >> 8), 1, "R11 high address");
        send_chk(8'(a16), 1, "R11 low address");
        i2c_start();
        send_chk(8'hA1, 1, "R11 read select");
        cur = a16 % DEPTH;
        recv_chk(n, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        tick(3);
        chk("R1 sda_oe in reset", int'(sda_oe), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        tick(4);
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        chk("R1 busy after reset", int'(busy), 0);

        // R2: no start, no answer
        scl = 1'b0; tick(Q);
        send_chk(8'hA0, 0, "R2 byte without start");
        i2c_stop();

        // R3: wrong device type, then silence until next start
        i2c_start();
        send_chk(8'hA2, 0, "R3 mismatched select");
        send_chk(8'hA0, 0, "R3 ignored until start");
        i2c_stop();
        i2c_start();
        send_chk(8'hB1, 0, "R3 wrong type read");
        i2c_stop();

        // R1: erased array
        rd_seq(16'h0005, 2, "R1 erased byte");

        // R8/R9: byte write, then bus activity during programming
        wr_seq(16'h0012, 1, 1, "R6 byte write ack");
        chk("R8 busy after stop", int'(busy), 1);
        i2c_start();
        send_chk(8'hA0, 0, "R9 select ignored while busy");
        i2c_stop();
        wait_prog();

        // R11, R10
        rd_seq(16'h0012, 1, "R11 random read");
        i2c_start();
        send_chk(8'hA1, 1, "R10 current read select");
        recv_chk(1, "R10 current address read");

        // R6: overlong page write wraps and overwrites
        wr_seq(16'h0085, PGB + 6, 2, "R6 page data ack");
        wait_prog();
        rd_seq(16'h007E, PGB + 4, "R6 page wrap readback");

        // R5: high address bits ignored
        wr_seq(16'hFF30, 3, 3, "R5 data ack");
        wait_prog();
        rd_seq(16'h0030, 3, "R5 aliased address");

        // R7: write control refuses data, array unchanged, no programming
        wc = 1'b1;
        i2c_start();
        send_chk(8'hA0, 1, "R7 select acked with wc");
        send_chk(8'h00, 1, "R7 high address acked with wc");
        send_chk(8'h40, 1, "R7 low address acked with wc");
        send_chk(8'h5A, 0, "R7 data refused");
        send_chk(8'hA5, 0, "R7 data refused");
        busy_cnt = 0;
        i2c_stop();
        tick(20);
        chk("R8 no data no busy", busy_cnt, 0);
        wc = 1'b0;
        rd_seq(16'h0040, 2, "R7 array unchanged");

        // R12: wrap at array top
        rd_seq(DEPTH - 2, 4, "R12 sequential wrap");

        // sweep: fill every page, read the whole array back
        for (int p = 0; p < DEPTH / PGB; p++) begin
            wr_seq(p * PGB, PGB, 10 + p, "R6 sweep data ack");
            wait_prog();
        end
        rd_seq(16'h0000, DEPTH + 4, "R12 sweep readback");
        i2c_start();
        send_chk(8'hA1, 1, "R10 select after sweep");
        recv_chk(2, "R10 continues after sweep");

        report();
    end
endmodule